// File: doc/BRIEF.md
# Windowed Watchdog Timer

A supervisory timer for a processor subsystem. A 7-bit down-counter is decremented by a tick derived from the peripheral clock through a fixed divider followed by a selectable power-of-two prescaler. Once software arms the timer, it must reload the counter inside a time window. The window opens when the counter drops to or below a programmed limit. It closes when the counter's top bit clears. A reload that comes too early, a reload with a value whose top bit is clear, or a missed window each produce a one-cycle reset request for the system reset controller. A flag, with an optional interrupt, warns software one tick before the counter runs out.

Software reaches the block through a plain strobe port. A write strobe with an address and data updates a register in one cycle. A read strobe returns a register combinationally on the read bus. The reset request also returns every register of the block to its reset value on the same clock edge.

Top module: `wwd_top`

## Requirements
- R1: After reset the control register reads 0x7F (counter 0x7F, armed bit 0), the configuration register reads 0x7F (limit 0x7F, prescale 0, interrupt enable 0), the status register reads 0, and `rst_req` and `warn_irq` are low.
- R2: The counter decrements once every FIX_DIV × 2^P clock cycles, where P is the prescale field, bits [8:7] of the configuration register (address 1).
- R3: The armed bit (control bit 7, address 0) can only be set by a write; writing 0 leaves it at 1. While it is 0, the counter keeps counting and wraps, and no reset request is produced.
- R4: While armed, a decrement from 0x40 to 0x3F raises `rst_req`.
- R5: While armed, a write to the control register while the counter is strictly above the limit (configuration bits [6:0]) raises `rst_req`. A write with the counter equal to or below the limit is accepted.
- R6: A control write whose counter field has bit 6 clear raises `rst_req` at once, if the armed bit is 1 before the write or is set by that write. When the block stays unarmed, the same write only loads the value.
- R7: The warning flag (status bit 0, address 2) is set when the counter decrements to 0x40, whatever the interrupt enable. If setting the flag and a software clear fall in the same cycle, setting wins.
- R8: Writing 0 to the status bit clears the flag. Writing 1 has no effect.
- R9: The interrupt enable (configuration bit 9) can only be set by a write; writing 0 does not clear it. `warn_irq` is high exactly when the flag and the enable are both 1.
- R10: `rst_req` is high for one cycle. On the edge that raises it, all registers return to their R1 values.
- R11: When a control write and a tick fall in the same cycle, the written value is loaded and the tick is dropped.
- R12: `rdata` is 0 when `rd_en` is low or when the address is 3. Writes to address 3 change nothing. Fields read back zero-extended at the positions given above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register select: 0 control, 1 configuration, 2 status |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, combinational |
| rst_req | output | 1 | One-cycle system reset request |
| warn_irq | output | 1 | Early-warning interrupt |

## Verification
Two pairs of functions can land on the same edge. In the first, the decrement that brings the counter to 0x40 meets a status write of 0. In the second, a tick meets a control reload. The bench hits both by counting edges from reset release, since the tick phase is fixed by then. It then reads the flag and the counter: the flag must be 1 and the counter must hold the written value. The window check is swept over every counter value from 0x40 to 0x7F against four limits, and the expected request is the strict comparison.

// File: rtl/wwd_pkg.sv
package wwd_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTL = 2'd0,
    SEL_CFG = 2'd1,
    SEL_STS = 2'd2,
    SEL_NUL = 2'd3
  } reg_sel_e;

  localparam int STS_FLAG_BIT = 0;
endpackage

// File: rtl/wwd_tick_gen.sv
module wwd_tick_gen #(
  parameter int FIX_DIV = 4096,
  parameter int PSEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  localparam int DIV_W = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;
  localparam int PRE_W = (1 << PSEL_W) - 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(FIX_DIV - 1);

  logic [DIV_W-1:0] div_q, div_nxt;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [PRE_W-1:0] mask;
  logic             base;

  assign base = (div_q == DIV_LAST);

  // thermometer mask: 2^psel - 1
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (i < int'(psel));
    end
  end

  assign tick = base && ((pre_q & mask) == mask);

  always_comb begin
    div_nxt = div_q;
    pre_nxt = pre_q;
    if (clr) begin
      div_nxt = '0;
      pre_nxt = '0;
    end else if (base) begin
      div_nxt = '0;
      pre_nxt = pre_q + 1'b1;
    end else begin
      div_nxt = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      pre_q <= '0;
    end else begin
      div_q <= div_nxt;
      pre_q <= pre_nxt;
    end
  end
endmodule

// File: rtl/wwd_down_counter.sv
module wwd_down_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctl_wr,
  input  logic [CNT_W-1:0] wr_cnt,
  input  logic             wr_act,
  input  logic [CNT_W-1:0] win,
  output logic [CNT_W-1:0] cnt_q,
  output logic             active_q,
  output logic             fault,
  output logic             warn_hit
);
  localparam logic [CNT_W-1:0] CNT_RST  = '1;
  localparam logic [CNT_W-1:0] TOP_VAL  = CNT_W'(1) << (CNT_W - 1);
  localparam logic [CNT_W-1:0] WARN_PRE = TOP_VAL + 1'b1;

  logic [CNT_W-1:0] cnt_nxt;
  logic             active_nxt;
  logic             underflow, early, low_load;
  logic             dec_en;

  assign dec_en    = tick && !ctl_wr;
  assign underflow = active_q && dec_en && (cnt_q == TOP_VAL);
  assign early     = active_q && ctl_wr && (cnt_q > win);
  assign low_load  = ctl_wr && (active_q || wr_act) && !wr_cnt[CNT_W-1];
  assign fault     = underflow || early || low_load;
  assign warn_hit  = dec_en && (cnt_q == WARN_PRE);

  always_comb begin
    cnt_nxt    = cnt_q;
    active_nxt = active_q;
    if (fault) begin
      cnt_nxt    = CNT_RST;
      active_nxt = 1'b0;
    end else if (ctl_wr) begin
      cnt_nxt    = wr_cnt;
      active_nxt = active_q || wr_act;
    end else if (tick) begin
      cnt_nxt    = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= CNT_RST;
      active_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_nxt;
      active_q <= active_nxt;
    end
  end
endmodule

// File: rtl/wwd_cfg_regs.sv
module wwd_cfg_regs #(
  parameter int CNT_W  = 7,
  parameter int PSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              cfg_wr,
  input  logic              sts_wr,
  input  logic [CNT_W-1:0]  wr_win,
  input  logic [PSEL_W-1:0] wr_psel,
  input  logic              wr_en_bit,
  input  logic              wr_flag_bit,
  input  logic              warn_hit,
  output logic [CNT_W-1:0]  win_q,
  output logic [PSEL_W-1:0] psel_q,
  output logic              irq_en_q,
  output logic              flag_q
);
  logic [CNT_W-1:0]  win_nxt;
  logic [PSEL_W-1:0] psel_nxt;
  logic              irq_en_nxt, flag_nxt;

  always_comb begin
    win_nxt    = win_q;
    psel_nxt   = psel_q;
    irq_en_nxt = irq_en_q;
    flag_nxt   = flag_q;
    if (clr) begin
      win_nxt    = '1;
      psel_nxt   = '0;
      irq_en_nxt = 1'b0;
      flag_nxt   = 1'b0;
    end else begin
      if (cfg_wr) begin
        win_nxt    = wr_win;
        psel_nxt   = wr_psel;
        irq_en_nxt = irq_en_q || wr_en_bit;
      end
      if (warn_hit) begin
        flag_nxt = 1'b1;
      end else if (sts_wr && !wr_flag_bit) begin
        flag_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q    <= '1;
      psel_q   <= '0;
      irq_en_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      win_q    <= win_nxt;
      psel_q   <= psel_nxt;
      irq_en_q <= irq_en_nxt;
      flag_q   <= flag_nxt;
    end
  end
endmodule

// File: rtl/wwd_top.sv
module wwd_top
  import wwd_pkg::*;
#(
  parameter int FIX_DIV = 4096,
  parameter int CNT_W   = 7,
  parameter int PSEL_W  = 2,
  parameter int DATA_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_req,
  output logic              warn_irq
);
  localparam int ACT_BIT  = CNT_W;
  localparam int PSEL_LSB = CNT_W;
  localparam int EN_BIT   = CNT_W + PSEL_W;

  logic              ctl_wr, cfg_wr, sts_wr;
  logic              tick, fault, warn_hit;
  logic [CNT_W-1:0]  cnt_q, win_q;
  logic              active_q, irq_en_q, flag_q;
  logic [PSEL_W-1:0] psel_q;
  logic              rst_req_q;
  logic              unused_wdata;

  assign ctl_wr = wr_en && (addr == SEL_CTL);
  assign cfg_wr = wr_en && (addr == SEL_CFG);
  assign sts_wr = wr_en && (addr == SEL_STS);
  assign unused_wdata = ^wdata;

  wwd_tick_gen #(
    .FIX_DIV (FIX_DIV),
    .PSEL_W  (PSEL_W)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fault),
    .psel  (psel_q),
    .tick  (tick)
  );

  wwd_down_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ctl_wr   (ctl_wr),
    .wr_cnt   (wdata[CNT_W-1:0]),
    .wr_act   (wdata[ACT_BIT]),
    .win      (win_q),
    .cnt_q    (cnt_q),
    .active_q (active_q),
    .fault    (fault),
    .warn_hit (warn_hit)
  );

  wwd_cfg_regs #(
    .CNT_W  (CNT_W),
    .PSEL_W (PSEL_W)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (fault),
    .cfg_wr      (cfg_wr),
    .sts_wr      (sts_wr),
    .wr_win      (wdata[CNT_W-1:0]),
    .wr_psel     (wdata[PSEL_LSB +: PSEL_W]),
    .wr_en_bit   (wdata[EN_BIT]),
    .wr_flag_bit (wdata[STS_FLAG_BIT]),
    .warn_hit    (warn_hit),
    .win_q       (win_q),
    .psel_q      (psel_q),
    .irq_en_q    (irq_en_q),
    .flag_q      (flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= fault;
    end
  end

  assign rst_req  = rst_req_q;
  assign warn_irq = flag_q && irq_en_q;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        SEL_CTL: rdata[ACT_BIT:0] = {active_q, cnt_q};
        SEL_CFG: rdata[EN_BIT:0]  = {irq_en_q, psel_q, win_q};
        SEL_STS: rdata[STS_FLAG_BIT] = flag_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wwd_chk.sv
module wwd_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_req,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] win,
  input logic             active,
  input logic             irq_en,
  input logic             flag,
  input logic             tick,
  input logic             ctl_wr,
  input logic             wr_act
);
  localparam logic [CNT_W-1:0] WARN_PRE = (CNT_W'(1) << (CNT_W - 1)) + 1'b1;

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R10

  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (cnt == '1) && (win == '1) && !active && !irq_en && !flag); // R10

  AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(active || (ctl_wr && wr_act))); // R3

  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) && !rst_req |-> active); // R3

  AST_ARMED_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cnt[CNT_W-1]); // R4

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(irq_en) && !rst_req |-> irq_en); // R9

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !ctl_wr && (cnt == WARN_PRE)) && !rst_req |-> flag); // R7

  AST_TICK_DECR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !ctl_wr) && !rst_req |-> cnt == CNT_W'($past(cnt) - 1'b1)); // R2
endmodule

bind wwd_top wwd_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rst_req (rst_req),
  .cnt     (cnt_q),
  .win     (win_q),
  .active  (active_q),
  .irq_en  (irq_en_q),
  .flag    (flag_q),
  .tick    (tick),
  .ctl_wr  (ctl_wr),
  .wr_act  (wdata[CNT_W])
);

// File: tb/wwd_top_tb.sv
`timescale 1ns/1ps
module wwd_top_tb;
  localparam int FD = 4;
  localparam logic [1:0] A_CTL = 2'd0, A_CFG = 2'd1, A_STS = 2'd2, A_NUL = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        rst_req, warn_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wwd_top #(.FIX_DIV(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rst_req(rst_req), .warn_irq(warn_irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic hard_reset();
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = 16'd0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_en = 1'b1; addr = a;
    #1;
    v = int'(rdata);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, v2;
    @(negedge clk);
    hard_reset();

    // R1 reset state
    rd(A_CTL, v); check(v == 'h7F, "R1 ctl", v, 'h7F);
    rd(A_CFG, v); check(v == 'h7F, "R1 cfg", v, 'h7F);
    rd(A_STS, v); check(v == 0, "R1 sts", v, 0);
    check(rst_req == 0 && warn_irq == 0, "R1 outputs", {rst_req, warn_irq}, 0);

    // R12 read strobe low and null address
    rd_en = 1'b0; addr = A_CTL; #1;
    check(rdata == 0, "R12 rd_en low", int'(rdata), 0);
    rd(A_NUL, v); check(v == 0, "R12 addr3 read", v, 0);
    wr(A_NUL, 16'hFFFF);
    rd(A_CFG, v); check(v == 'h7F, "R12 addr3 write cfg", v, 'h7F);
    rd(A_STS, v); check(v == 0, "R12 addr3 write sts", v, 0);
    check(rst_req == 0, "R12 addr3 write req", rst_req, 0);

    // R2 prescaler sweep: gap between later decrements
    for (int p = 0; p < 4; p++) begin
      int prev, nchg, t1, t2, cyc;
      hard_reset();
      wr(A_CFG, 16'(('h7F) | (p << 7)));
      rd(A_CTL, prev);
      nchg = 0; t1 = 0; t2 = 0; cyc = 0;
      while (nchg < 3 && cyc < 2000) begin
        idle(1); cyc++;
        rd(A_CTL, v);
        if (v != prev) begin
          nchg++;
          if (nchg == 2) t1 = cyc;
          if (nchg == 3) t2 = cyc;
          prev = v;
        end
      end
      check(t2 - t1 == (FD << p), "R2 tick period", t2 - t1, FD << p);
    end

    // R11 reload collides with a tick (tick on edge 4)
    hard_reset();
    idle(3);
    wr(A_CTL, 16'h0070);
    rd(A_CTL, v); check(v == 'h70, "R11 load wins", v, 'h70);
    idle(4);
    rd(A_CTL, v); check(v == 'h6F, "R2 next decrement", v, 'h6F);

    // R3/R7/R8/R9 unarmed run through 0x40 and below
    hard_reset();
    wr(A_CTL, 16'h0041);              // edge 1
    for (int k = 0; k < 12; k++) begin
      idle(1);
      check(rst_req == 0, "R3 no req unarmed", rst_req, 0);
    end
    rd(A_CTL, v); check(v == 'h3E, "R3 counts unarmed", v, 'h3E);
    rd(A_STS, v); check(v == 1, "R7 flag without enable", v, 1);
    check(warn_irq == 0, "R9 irq off when disabled", warn_irq, 0);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); check(v == 1, "R8 write 1 keeps flag", v, 1);
    wr(A_STS, 16'h0000);
    rd(A_STS, v); check(v == 0, "R8 write 0 clears", v, 0);
    wr(A_STS, 16'h0001);
    rd(A_STS, v); check(v == 0, "R8 write 1 does not set", v, 0);

    // R3 wrap while unarmed: 0x00 -> 0x7F
    hard_reset();
    wr(A_CTL, 16'h0001);              // edge 1
    idle(3);                          // edge 4: 0x00
    rd(A_CTL, v); check(v == 'h00, "R3 reach zero", v, 0);
    idle(4);                          // edge 8: wrap
    rd(A_CTL, v); check(v == 'h7F, "R3 wrap", v, 'h7F);
    check(rst_req == 0, "R3 wrap no req", rst_req, 0);

    // R7 set collides with clear (tick on edge 4)
    hard_reset();
    wr(A_CTL, 16'h0041);              // edge 1
    idle(2);
    wr(A_STS, 16'h0000);              // edge 4
    rd(A_STS, v); check(v == 1, "R7 set beats clear", v, 1);

    // R3 armed bit sticky; R9 enable sticky
    hard_reset();
    wr(A_CTL, 16'h00FF);
    wr(A_CTL, 16'h007F);              // counter equals limit: legal
    rd(A_CTL, v); check(v == 'hFF, "R3 arm sticky", v, 'hFF);
    check(rst_req == 0, "R5 equal accepted", rst_req, 0);
    hard_reset();
    wr(A_CFG, 16'h0260);
    wr(A_CFG, 16'h0060);
    rd(A_CFG, v); check(v == 'h260, "R9 enable sticky", v, 'h260);

    // R4/R7/R9/R10 armed underflow
    hard_reset();
    wr(A_CFG, 16'h027F);              // edge 1
    wr(A_CTL, 16'h00C1);              // edge 2
    idle(2);                          // edge 4: 0x40
    rd(A_STS, v); check(v == 1, "R7 flag at 0x40", v, 1);
    check(warn_irq == 1, "R9 irq on", warn_irq, 1);
    for (int k = 0; k < 3; k++) begin
      idle(1);
      check(rst_req == 0, "R4 no early req", rst_req, 0);
    end
    idle(1);                          // edge 8: underflow
    check(rst_req == 1, "R4 underflow req", rst_req, 1);
    rd(A_CTL, v);  check(v == 'h7F, "R10 ctl cleared", v, 'h7F);
    rd(A_CFG, v2); check(v2 == 'h7F, "R10 cfg cleared", v2, 'h7F);
    rd(A_STS, v);  check(v == 0, "R10 flag cleared", v, 0);
    check(warn_irq == 0, "R10 irq cleared", warn_irq, 0);
    idle(1);
    check(rst_req == 0, "R10 single pulse", rst_req, 0);

    // R6 sweep of loaded value, armed and unarmed
    for (int c = 0; c < 128; c++) begin
      hard_reset();
      wr(A_CTL, 16'(c));
      check(rst_req == 0, "R6 unarmed load", rst_req, 0);
      rd(A_CTL, v); check(v == c, "R12 ctl readback", v, c);
      hard_reset();
      wr(A_CTL, 16'(c | 'h80));
      check(rst_req == (c < 'h40), "R6 armed low load", rst_req, c < 'h40);
    end

    // R5 window sweep: reload with counter c against limit w (edge 3)
    for (int wi = 0; wi < 4; wi++) begin
      int w;
      w = 'h40 + wi * 'h15;
      for (int c = 'h40; c < 'h80; c++) begin
        bit exp_f;
        exp_f = (c > w);
        hard_reset();
        wr(A_CFG, 16'(w));
        wr(A_CTL, 16'(c | 'h80));
        wr(A_CTL, 16'h00FF);
        check(rst_req == exp_f, "R5 window", rst_req, exp_f);
        rd(A_CTL, v);
        check(v == (exp_f ? 'h7F : 'hFF), "R10 state after reload", v, exp_f ? 'h7F : 'hFF);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule